// File: doc/BRIEF.md
# Write-Once Flash Page Staging Buffer

This block holds one page of 16-bit words while software assembles the data for a flash page write. A load strobe writes one word into the slot chosen by a word-offset index. The sequencer that later programs the array reads the slots back by index, one slot per cycle. A per-slot occupancy map records which slots already hold data. A slot accepts exactly one write between clears. A second write to the same slot is dropped, and the block reports it with a single-cycle error pulse.

The whole buffer returns to the erased state of all ones (0xFFFF, the same value as erased flash) on any of four events: synchronous reset, completion of a page write, the command that re-enables reading of the read-while-write region, and a data-EEPROM write. An EEPROM write in the middle of loading therefore discards everything loaded so far. The page size in words is a parameter.

Top module: `page_stage_buf`

## Requirements
- R1: While `rst_n` is low at a clock edge, every slot becomes 0xFFFF, `used_map` becomes all zero, `dup_err` becomes 0 and `rd_data` becomes 0xFFFF.
- R2: A load (`ld_en` high) to a slot whose `used_map` bit is 0 stores `ld_data` in slot `ld_idx` and sets bit `ld_idx` of `used_map` at that edge.
- R3: `rd_data` shows the contents of slot `rd_idx` one cycle after `rd_idx` is presented. The value is the contents before any load made at that same edge.
- R4: A load to a slot whose `used_map` bit is already 1 leaves that slot's contents unchanged.
- R5: `dup_err` is 1 for exactly the one cycle after a load to an already-used slot is rejected, and is 0 otherwise.
- R6: A `pg_done` pulse clears every slot to 0xFFFF and `used_map` to zero at that edge.
- R7: A `rww_reen` pulse clears every slot to 0xFFFF and `used_map` to zero at that edge.
- R8: An `ee_wr` pulse discards all loaded words: every slot reads 0xFFFF and `used_map` is zero after that edge.
- R9: When a clear event coincides with a load, the clear wins. The load is dropped and `dup_err` stays 0.
- R10: After any clear, a slot that was written before accepts a new write without raising `dup_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Word load strobe |
| ld_idx | input | IDX_W | Word offset of the slot to load |
| ld_data | input | DATA_W | Word to load |
| pg_done | input | 1 | Page write completed (clear pulse) |
| rww_reen | input | 1 | Read-while-write region re-enable command (clear pulse) |
| ee_wr | input | 1 | Data-EEPROM write started (clear pulse) |
| rd_idx | input | IDX_W | Slot index for the sequencer read port |
| rd_data | output | DATA_W | Registered contents of slot `rd_idx` |
| used_map | output | WORDS | One bit per slot, set once the slot has been written |
| dup_err | output | 1 | One-cycle pulse after a rejected duplicate load |

## Verification
The bench builds the block with an 8-word page, keeping the 16-bit word width. With eight words, every slot, including the highest index, can be written, duplicated and read back within a few hundred cycles, so the occupancy map is checked as a whole value. The small page also makes it cheap to run each of the three clear pulses, and a clear colliding with a load, on both an empty and a partly filled buffer.

// File: rtl/ps_pkg.sv
// Shared types for the page staging buffer.
// Assumes 16-bit flash words whose erased value is all ones.
package ps_pkg;
    localparam int WORD_W = 16;
    typedef logic [WORD_W-1:0] word_t;
    localparam word_t ERASED_WORD = '1;

    // Events that empty the buffer
    typedef struct packed {
        logic pg_done;
        logic rww_reen;
        logic ee_wr;
    } clr_src_t;
endpackage

// File: rtl/ps_clear_ctl.sv
// Merges the buffer-emptying events into one clear strobe.
// Assumes every event is a single-cycle pulse in the clk domain.
module ps_clear_ctl
    import ps_pkg::*;
(
    input  clr_src_t src_i,
    output logic     clr_o
);
    // Any one event empties the whole page
    always_comb begin
        clr_o = src_i.pg_done | src_i.rww_reen | src_i.ee_wr;
    end
endmodule

// File: rtl/ps_slot_map.sv
// Keeps the written-slot map and decides which loads are accepted.
// A slot accepts one load per clear; a clear in the same cycle drops the load.
// Assumes WORDS is a power of two so every ld_idx value names a slot.
module ps_slot_map #(
    parameter int WORDS = 64,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             ld_en_i,
    input  logic [IDX_W-1:0] ld_idx_i,
    output logic [WORDS-1:0] wr_en_o,
    output logic [WORDS-1:0] used_o,
    output logic             dup_o
);
    logic [WORDS-1:0] used_q;
    logic             dup_q;
    logic             dup_hit;

    // Per-slot accept decode: unused slot, no clear pending
    for (genvar g = 0; g < WORDS; g++) begin : g_dec
        always_comb begin
            wr_en_o[g] = ld_en_i && !clr_i && (ld_idx_i == IDX_W'(g)) && !used_q[g];
        end
    end

    // Duplicate detection for the addressed slot
    always_comb begin
        dup_hit = ld_en_i && !clr_i && used_q[ld_idx_i];
    end

    // Occupancy map: emptied by reset or clear, grows with accepted loads
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            used_q <= '0;
        end else begin
            used_q <= used_q | wr_en_o;
        end
    end

    // Error pulse register, one cycle per rejected load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dup_q <= 1'b0;
        end else begin
            dup_q <= dup_hit;
        end
    end

    assign used_o = used_q;
    assign dup_o  = dup_q;

    // R5
    dup_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en_i && !clr_i && used_q[ld_idx_i]) |=> dup_o);
    // R5
    dup_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dup_o |-> $past(ld_en_i));
    // R6
    clr_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (used_o == '0));
    // R9
    clr_no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !dup_o);
endmodule

// File: rtl/ps_word_store.sv
// Word storage for one page plus a registered read port.
// Slots reload to the erased value on reset or clear.
// Assumes wr_en_i is one-hot or zero; the read port sees pre-write contents.
module ps_word_store
    import ps_pkg::*;
#(
    parameter int WORDS = 64,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [WORDS-1:0] wr_en_i,
    input  word_t            wr_data_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output word_t            rd_data_o
);
    word_t slot_q [WORDS];
    word_t rd_q;

    for (genvar g = 0; g < WORDS; g++) begin : g_slot
        // Slot register: erased on reset or clear, loaded on its enable
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
                slot_q[g] <= ERASED_WORD;
            end else if (wr_en_i[g]) begin
                slot_q[g] <= wr_data_i;
            end
        end

        // R2
        slot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en_i[g] |=> (slot_q[g] == $past(wr_data_i)));
        // R4
        slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en_i[g] && !clr_i) |=> $stable(slot_q[g]));
        // R7
        slot_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i |=> (slot_q[g] == ERASED_WORD));
    end

    // Read port register for the page-write sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= ERASED_WORD;
        end else begin
            rd_q <= slot_q[rd_idx_i];
        end
    end

    assign rd_data_o = rd_q;
endmodule

// File: rtl/page_stage_buf.sv
// Write-once staging buffer for one flash page.
// Connects clear merging, the slot map and the word store.
// Assumes all inputs are synchronous to clk and WORDS is a power of two.
module page_stage_buf
    import ps_pkg::*;
#(
    parameter int WORDS = 64,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              pg_done,
    input  logic              rww_reen,
    input  logic              ee_wr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [WORDS-1:0]  used_map,
    output logic              dup_err
);
    clr_src_t         src;
    logic             clr;
    logic [WORDS-1:0] wr_en;
    word_t            rd_w;

    // Gather the clear events into the package struct
    always_comb begin
        src.pg_done  = pg_done;
        src.rww_reen = rww_reen;
        src.ee_wr    = ee_wr;
    end

    ps_clear_ctl u_clr (
        .src_i (src),
        .clr_o (clr)
    );

    ps_slot_map #(.WORDS(WORDS)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr),
        .ld_en_i  (ld_en),
        .ld_idx_i (ld_idx),
        .wr_en_o  (wr_en),
        .used_o   (used_map),
        .dup_o    (dup_err)
    );

    ps_word_store #(.WORDS(WORDS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .wr_en_i   (wr_en),
        .wr_data_i (word_t'(ld_data)),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_w)
    );

    assign rd_data = DATA_W'(rd_w);

    // R1
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> (used_map == '0 && !dup_err && rd_data == '1));
    // R8
    ee_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_wr |=> (used_map == '0));
endmodule

// File: tb/page_stage_buf_tb.sv
// Directed bench for page_stage_buf, built with an 8-word page.
module page_stage_buf_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS = 8;
    localparam int IDX_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_en = 1'b0;
    logic [IDX_W-1:0] ld_idx = '0;
    logic [15:0] ld_data = '0;
    logic pg_done = 1'b0, rww_reen = 1'b0, ee_wr = 1'b0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [15:0] rd_data;
    logic [WORDS-1:0] used_map;
    logic dup_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_stage_buf #(.WORDS(WORDS), .DATA_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx),
        .ld_data(ld_data), .pg_done(pg_done), .rww_reen(rww_reen),
        .ee_wr(ee_wr), .rd_idx(rd_idx), .rd_data(rd_data),
        .used_map(used_map), .dup_err(dup_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // One load cycle; returns dup_err seen after the edge
    task automatic load(input int idx, input logic [15:0] d, output logic dup);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = IDX_W'(idx); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        dup = dup_err;
    endtask

    task automatic rd(input int idx, output logic [15:0] v);
        @(negedge clk);
        rd_idx = IDX_W'(idx);
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic check_empty(input string req);
        logic [15:0] v;
        chk(used_map == '0, req, 32'(used_map), 0);
        for (int i = 0; i < WORDS; i++) begin
            rd(i, v);
            chk(v == 16'hFFFF, req, 32'(v), 32'hFFFF);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk(dup_err == 1'b0, "R1", 32'(dup_err), 0);
        chk(rd_data == 16'hFFFF, "R1", 32'(rd_data), 32'hFFFF);
        check_empty("R1");
    endtask

    task automatic t_load_read();
        logic dup; logic [15:0] v;
        for (int i = 0; i < WORDS; i++) begin
            load(i, 16'h1000 + 16'(i * 17), dup);
            chk(dup == 1'b0, "R2", 32'(dup), 0);
        end
        chk(used_map == 8'hFF, "R2", 32'(used_map), 32'hFF);
        for (int i = WORDS - 1; i >= 0; i--) begin
            rd(i, v);
            chk(v == 16'h1000 + 16'(i * 17), "R3", 32'(v), 32'(16'h1000 + 16'(i * 17)));
        end
    endtask

    task automatic t_dup();
        logic dup; logic [15:0] v;
        load(2, 16'hDEAD, dup);
        chk(dup == 1'b1, "R5", 32'(dup), 1);
        @(negedge clk);
        chk(dup_err == 1'b0, "R5", 32'(dup_err), 0);
        rd(2, v);
        chk(v == 16'h1022, "R4", 32'(v), 32'h1022);
        load(7, 16'h0000, dup);
        chk(dup == 1'b1, "R5", 32'(dup), 1);
        rd(7, v);
        chk(v == 16'h1077, "R4", 32'(v), 32'h1077);
        chk(used_map == 8'hFF, "R4", 32'(used_map), 32'hFF);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: pg_done = 1'b1;
            1: rww_reen = 1'b1;
            default: ee_wr = 1'b1;
        endcase
        @(negedge clk);
        pg_done = 1'b0; rww_reen = 1'b0; ee_wr = 1'b0;
    endtask

    task automatic t_clears();
        logic dup; logic [15:0] v;
        pulse(0);
        check_empty("R6");
        load(3, 16'hA5A5, dup); load(0, 16'h0001, dup);
        chk(used_map == 8'h09, "R2", 32'(used_map), 32'h09);
        pulse(1);
        check_empty("R7");
        load(5, 16'h5A5A, dup); load(6, 16'h6666, dup);
        pulse(2);
        check_empty("R8");
        load(5, 16'hBEEF, dup);
        chk(dup == 1'b0, "R10", 32'(dup), 0);
        rd(5, v);
        chk(v == 16'hBEEF, "R10", 32'(v), 32'hBEEF);
    endtask

    task automatic t_collide();
        logic [15:0] v;
        // clear plus load on the used slot 5 and on unused slot 1
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 3'd5; ld_data = 16'h1234; ee_wr = 1'b1;
        @(negedge clk);
        ld_en = 1'b0; ee_wr = 1'b0;
        chk(dup_err == 1'b0, "R9", 32'(dup_err), 0);
        chk(used_map == '0, "R9", 32'(used_map), 0);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 3'd1; ld_data = 16'h4321; pg_done = 1'b1;
        @(negedge clk);
        ld_en = 1'b0; pg_done = 1'b0;
        chk(used_map == '0, "R9", 32'(used_map), 0);
        rd(1, v);
        chk(v == 16'hFFFF, "R9", 32'(v), 32'hFFFF);
    endtask

    task automatic t_same_cycle_read();
        // load slot 4 while reading it: old value first, new value next
        @(negedge clk);
        rd_idx = 3'd4; ld_en = 1'b1; ld_idx = 3'd4; ld_data = 16'h7E57;
        @(negedge clk);
        ld_en = 1'b0;
        chk(rd_data == 16'hFFFF, "R3", 32'(rd_data), 32'hFFFF);
        @(negedge clk);
        chk(rd_data == 16'h7E57, "R3", 32'(rd_data), 32'h7E57);
    endtask

    task automatic t_reset_mid();
        logic dup;
        load(0, 16'hCAFE, dup);
        do_reset();
        check_empty("R1");
    endtask

    initial begin
        t_reset();
        t_load_read();
        t_dup();
        t_clears();
        t_collide();
        t_same_cycle_read();
        t_reset_mid();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule